// File: doc/BRIEF.md
# Token-Aware Data Cache Controller

This block is a small direct-mapped write-back data cache. Each line is 64 bytes wide and carries one extra marker bit. A secret 512-bit pattern is held in a configuration register. Every line that arrives from memory is compared with that pattern, and a full match sets the line's marker. The cache then refuses ordinary loads and stores to the marked line and reports a violation instead of the data. When a marked line leaves the cache, the secret pattern itself is written back, whatever the data array holds for that slot.

Software places markers with an arm request, which is an aligned full-line write that sets the marker. It removes them with a disarm request, the only request allowed on a marked line; disarm clears the marker and zeroes the line. The core side presents one request at a time and waits for a one-cycle ready pulse. The memory side moves whole lines through a request/acknowledge handshake. A miss writes back a dirty victim first and then fills the line.

Top module: `tkc_cache`

## Requirements
- R1: After the token is loaded through the configuration port, a line whose filled data equals the token is marked, and a load to any byte of it responds with rsp_viol=1.
- R2: A load (req_op=0) returns 2^req_size bytes starting at the byte offset, little-endian and zero-extended in rsp_data. Bytes past the end of the line read as zero.
- R3: A store (req_op=1) writes the low 2^req_size bytes of req_wdata from the byte offset, changes no other byte and returns rsp_data=0.
- R4: A miss whose victim is valid and dirty first writes the victim back (mem_we=1, mem_addr = victim line address) and then fills the requested line.
- R5: When a marked dirty line is evicted, mem_wdata equals the token value.
- R6: An arm (req_op=2) to an aligned unmarked line writes the line and sets its marker. Later loads and stores to that line violate.
- R7: A violating load or store returns rsp_data=0 and leaves the marker set, so a repeated access violates again.
- R8: A disarm (req_op=3) of an aligned marked line clears the marker, sets the line to zeros and marks it dirty, so its eviction writes zeros.
- R9: An arm or disarm whose address bits [5:0] are not zero responds with a violation, changes nothing and starts no memory transfer.
- R10: An arm of a marked line or a disarm of an unmarked line responds with a violation and changes nothing.
- R11: Each accepted request produces exactly one rsp_ready pulse of one cycle; rsp_viol is only high together with rsp_ready.
- R12: mem_req stays high with stable mem_addr, mem_we and mem_wdata until mem_ack; mem_addr is a line address (byte address bits above the offset).
- R13: Reset invalidates every line and drives rsp_ready, rsp_viol and mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tok_we | input | 1 | Load the token register |
| cfg_tok_data | input | 512 | Token value |
| req_valid | input | 1 | Request present (accepted when idle) |
| req_op | input | 2 | 0 load, 1 store, 2 arm, 3 disarm |
| req_addr | input | 16 | Byte address |
| req_size | input | 2 | log2 of access size in bytes |
| req_wdata | input | 512 | Store data (low bytes) or arm line data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_viol | output | 1 | Violation flag, valid with rsp_ready |
| rsp_data | output | 64 | Load data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 writeback, 0 fill |
| mem_addr | output | 10 | Line address |
| mem_wdata | output | 512 | Writeback line |
| mem_ack | input | 1 | Transfer done |
| mem_rdata | input | 512 | Fill line, valid with mem_ack |

## Verification
Loads of several sizes and offsets, including one that runs past the line end, tell correct byte selection apart from shifted or truncated data. A line whose memory content equals the token is compared against ordinary lines to show that the fill comparator sets the marker. Arm, repeated arm, misaligned arm, disarm of an unmarked line and valid disarm tell which of those requests may change state. Three chained evictions, one dirty plain line, one disarmed line and one armed line, show that the writeback carries stored data, zeros and the token in turn.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ARM    = 2'd2,
    OP_DISARM = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } state_e;
endpackage

// File: rtl/tkc_token_unit.sv
// Token register plus the single line-wide equality comparator on the fill path.
module tkc_token_unit #(
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [LINE_W-1:0] cfg_data,
  input  logic [LINE_W-1:0] fill_data,
  output logic [LINE_W-1:0] token,
  output logic              match
);
  always_ff @(posedge clk) begin
    if (rst) token <= '0;
    else if (cfg_we) token <= cfg_data;
  end

  assign match = (fill_data == token);
endmodule

// File: rtl/tkc_tag_store.sv
// Per-set valid, tag, dirty and marker bits.
module tkc_tag_store #(
  parameter int SETS  = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  output logic             rd_tok,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic             wr_tok
);
  logic [SETS-1:0]  valid_q, dirty_q, tok_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      tok_q   <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= wr_valid;
      dirty_q[idx] <= wr_dirty;
      tok_q[idx]   <= wr_tok;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx] <= wr_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tok   = tok_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/tkc_data_array.sv
// Line storage with a byte-enabled write port.
module tkc_data_array #(
  parameter int SETS       = 4,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      idx,
  input  logic [LINE_BYTES-1:0] be,
  input  logic [LINE_W-1:0]     wdata,
  output logic [LINE_W-1:0]     rdata
);
  logic [LINE_W-1:0] mem_q [SETS];

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (be[b]) mem_q[idx][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/tkc_cache.sv
module tkc_cache
  import tkc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int DW         = 64
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_tok_we,
  input  logic [8*LINE_BYTES-1:0]                cfg_tok_data,
  input  logic                                   req_valid,
  input  logic [1:0]                             req_op,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [1:0]                             req_size,
  input  logic [8*LINE_BYTES-1:0]                req_wdata,
  output logic                                   rsp_ready,
  output logic                                   rsp_viol,
  output logic [DW-1:0]                          rsp_data,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_addr,
  output logic [8*LINE_BYTES-1:0]                mem_wdata,
  input  logic                                   mem_ack,
  input  logic [8*LINE_BYTES-1:0]                mem_rdata
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W  = 8 * LINE_BYTES;
  localparam int DBYTES  = DW / 8;

  state_e              state_q, state_d;
  op_e                 op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [1:0]          size_q;
  logic [LINE_W-1:0]   wdata_q;

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic [OFF_W-1:0]    off;
  logic                hit;

  logic                rd_valid, rd_dirty, rd_tok;
  logic [TAG_W-1:0]    rd_tag;
  logic                ts_we, ts_valid, ts_dirty, ts_tok;
  logic [LINE_BYTES-1:0] be;
  logic [LINE_W-1:0]   wline;
  logic [LINE_W-1:0]   line_rd;
  logic [LINE_W-1:0]   token;
  logic                tok_match;

  logic                rsp_go, viol_d;
  logic [DW-1:0]       data_d;
  logic [DW-1:0]       load_val;

  assign idx = addr_q[OFF_W +: IDX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];
  assign off = addr_q[OFF_W-1:0];
  assign hit = rd_valid && (rd_tag == tag);

  tkc_token_unit #(.LINE_W(LINE_W)) u_tok (
    .clk(clk), .rst(rst), .cfg_we(cfg_tok_we), .cfg_data(cfg_tok_data),
    .fill_data(mem_rdata), .token(token), .match(tok_match)
  );

  tkc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_dirty(rd_dirty), .rd_tok(rd_tok),
    .wr_en(ts_we), .wr_valid(ts_valid), .wr_tag(tag), .wr_dirty(ts_dirty),
    .wr_tok(ts_tok)
  );

  tkc_data_array #(.SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_data (
    .clk(clk), .idx(idx), .be(be), .wdata(wline), .rdata(line_rd)
  );

  // Load byte extraction: bytes past the line end read as zero.
  always_comb begin
    load_val = '0;
    for (int i = 0; i < DBYTES; i++) begin
      if (i < (1 << size_q) && (int'(off) + i) < LINE_BYTES)
        load_val[8*i +: 8] = line_rd[8*(int'(off) + i) +: 8];
    end
  end

  always_comb begin
    state_d  = state_q;
    be       = '0;
    wline    = '0;
    ts_we    = 1'b0;
    ts_valid = rd_valid;
    ts_dirty = rd_dirty;
    ts_tok   = rd_tok;
    rsp_go   = 1'b0;
    viol_d   = 1'b0;
    data_d   = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if ((op_q == OP_ARM || op_q == OP_DISARM) && off != '0) begin
          rsp_go  = 1'b1;
          viol_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (!hit) begin
          state_d = (rd_valid && rd_dirty) ? ST_WB : ST_FILL;
        end else begin
          rsp_go  = 1'b1;
          state_d = ST_IDLE;
          unique case (op_q)
            OP_LOAD: begin
              if (rd_tok) viol_d = 1'b1;
              else data_d = load_val;
            end
            OP_STORE: begin
              if (rd_tok) viol_d = 1'b1;
              else begin
                ts_we    = 1'b1;
                ts_dirty = 1'b1;
                for (int b = 0; b < LINE_BYTES; b++) begin
                  if (b >= int'(off) && (b - int'(off)) < (1 << size_q)) begin
                    be[b]           = 1'b1;
                    wline[8*b +: 8] = wdata_q[8*(b - int'(off)) +: 8];
                  end
                end
              end
            end
            OP_ARM: begin
              if (rd_tok) viol_d = 1'b1;
              else begin
                ts_we    = 1'b1;
                ts_dirty = 1'b1;
                ts_tok   = 1'b1;
                be       = '1;
                wline    = wdata_q;
              end
            end
            OP_DISARM: begin
              if (!rd_tok) viol_d = 1'b1;
              else begin
                ts_we    = 1'b1;
                ts_dirty = 1'b1;
                ts_tok   = 1'b0;
                be       = '1;
                wline    = '0;
              end
            end
            default: ;
          endcase
        end
      end
      ST_WB: if (mem_ack) state_d = ST_FILL;
      ST_FILL: begin
        if (mem_ack) begin
          be       = '1;
          wline    = mem_rdata;
          ts_we    = 1'b1;
          ts_valid = 1'b1;
          ts_dirty = 1'b0;
          ts_tok   = tok_match;
          state_d  = ST_LOOK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rsp_ready <= 1'b0;
      rsp_viol  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state_q   <= state_d;
      rsp_ready <= rsp_go;
      rsp_viol  <= rsp_go && viol_d;
      rsp_data  <= rsp_go ? data_d : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && req_valid) begin
      op_q    <= op_e'(req_op);
      addr_q  <= req_addr;
      size_q  <= req_size;
      wdata_q <= req_wdata;
    end
  end

  // Memory side: writeback pushes the token for a marked victim.
  assign mem_req   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? {rd_tag, idx} : addr_q[ADDR_W-1:OFF_W];
  assign mem_wdata = rd_tok ? token : line_rd;
endmodule

// File: rtl/tkc_cache_chk.sv
module tkc_cache_chk #(
  parameter int DW      = 64,
  parameter int LINE_W  = 512,
  parameter int LADDR_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               rsp_ready,
  input logic               rsp_viol,
  input logic [DW-1:0]      rsp_data,
  input logic               mem_req,
  input logic               mem_we,
  input logic [LADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0]  mem_wdata,
  input logic               mem_ack
);
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);

  a_r11_viol_with_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_viol |-> rsp_ready);

  a_r7_viol_zero_data: assert property (@(posedge clk) disable iff (rst)
    rsp_viol |-> rsp_data == '0);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

  a_r13_quiet_on_resp: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> !mem_req);
endmodule

bind tkc_cache tkc_cache_chk #(
  .DW(DW), .LINE_W(8*LINE_BYTES), .LADDR_W(ADDR_W-$clog2(LINE_BYTES))
) u_chk (
  .clk(clk), .rst(rst), .rsp_ready(rsp_ready), .rsp_viol(rsp_viol),
  .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_tkc_cache.sv
`timescale 1ns/1ps
module tb_tkc_cache;
  localparam logic [511:0] TOKEN = {16{32'h5A3C_96E1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_tok_we = 1'b0;
  logic [511:0] cfg_tok_data = '0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_op = '0;
  logic [15:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [511:0] req_wdata = '0;
  logic         rsp_ready, rsp_viol;
  logic [63:0]  rsp_data;
  logic         mem_req, mem_we;
  logic [9:0]   mem_addr;
  logic [511:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [511:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tkc_cache dut (
    .clk(clk), .rst(rst), .cfg_tok_we(cfg_tok_we), .cfg_tok_data(cfg_tok_data),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_viol(rsp_viol), .rsp_data(rsp_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: byte b of line L holds (L*7+b) mod 256, line 5 holds the token.
  logic [511:0] mem [16];
  int wb_count = 0, fill_count = 0, wait_cnt = 0;
  logic [9:0]   last_wb_addr;
  logic [511:0] last_wb_data;

  initial begin
    for (int l = 0; l < 16; l++)
      for (int b = 0; b < 64; b++) mem[l][8*b +: 8] = 8'(l*7 + b);
    mem[5] = TOKEN;
  end

  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      wait_cnt++;
      if (wait_cnt == 2) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[3:0]] = mem_wdata;
          last_wb_addr = mem_addr;
          last_wb_data = mem_wdata;
          wb_count++;
        end else begin
          mem_rdata = mem[mem_addr[3:0]];
          fill_count++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [15:0] a, input logic [1:0] sz,
                         input logic [511:0] wd, output logic [63:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_ready) @(negedge clk);
    d = rsp_data;
    v = rsp_viol;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [1:0]  sz;
    logic [63:0] wd;
    logic [63:0] exp_d;
    logic        exp_v;
    logic [7:0]  rq;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{2'd0, 16'h0040, 2'd3, 64'h0, 64'h0E0D0C0B0A090807, 1'b0, 8'd2},  // R2 line fill + 8-byte load
    '{2'd0, 16'h0043, 2'd1, 64'h0, 64'h0B0A,             1'b0, 8'd2},  // R2 2-byte load at offset
    '{2'd1, 16'h0044, 2'd2, 64'hDEADBEEF, 64'h0,         1'b0, 8'd3},  // R3 store 4 bytes
    '{2'd0, 16'h0040, 2'd3, 64'h0, 64'hDEADBEEF0A090807, 1'b0, 8'd3},  // R3 neighbours untouched
    '{2'd0, 16'h017E, 2'd3, 64'h0, 64'h0,                1'b1, 8'd1},  // R1 token-filled line
    '{2'd2, 16'h0080, 2'd0, 64'h0, 64'h0,                1'b0, 8'd6},  // R6 arm
    '{2'd0, 16'h0088, 2'd0, 64'h0, 64'h0,                1'b1, 8'd6},  // R6 load to armed line
    '{2'd1, 16'h0081, 2'd0, 64'h77, 64'h0,               1'b1, 8'd7},  // R7 store to armed line
    '{2'd2, 16'h0080, 2'd0, 64'h0, 64'h0,                1'b1, 8'd10}, // R10 re-arm
    '{2'd2, 16'h00C4, 2'd0, 64'h0, 64'h0,                1'b1, 8'd9},  // R9 misaligned arm
    '{2'd3, 16'h00C0, 2'd0, 64'h0, 64'h0,                1'b1, 8'd10}, // R10 disarm unmarked
    '{2'd3, 16'h0080, 2'd0, 64'h0, 64'h0,                1'b0, 8'd8},  // R8 disarm
    '{2'd0, 16'h0080, 2'd3, 64'h0, 64'h0,                1'b0, 8'd8},  // R8 zeros after disarm
    '{2'd0, 16'h017F, 2'd0, 64'h0, 64'h0,                1'b1, 8'd7},  // R7 marker kept
    '{2'd0, 16'h007E, 2'd3, 64'h0, 64'h4645,             1'b0, 8'd2},  // R2 past line end
    '{2'd0, 16'h0044, 2'd2, 64'h0, 64'hDEADBEEF,         1'b0, 8'd4}   // R4 written back data
  };

  initial begin
    logic [63:0] d;
    logic        v;
    int          f0, w0;

    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13 rsp_ready", 512'(rsp_ready), 512'(0));
    chk("R13 mem_req", 512'(mem_req), 512'(0));
    rst = 1'b0;
    @(negedge clk);
    cfg_tok_we = 1'b1; cfg_tok_data = TOKEN;   // R1 token load
    @(negedge clk);
    cfg_tok_we = 1'b0;

    for (int i = 0; i < 16; i++) begin
      run_req(VEC[i].op, VEC[i].addr, VEC[i].sz, 512'(VEC[i].wd), d, v);
      chk($sformatf("R%0d vec%0d data", VEC[i].rq, i), 512'(d), 512'(VEC[i].exp_d));
      chk($sformatf("R%0d vec%0d viol", VEC[i].rq, i), 512'(v), 512'(VEC[i].exp_v));
    end

    // R11 ready lasts one cycle
    chk("R11 ready dropped", 512'(rsp_ready), 512'(0));

    // R4 / R12 dirty victim written back to its line address
    chk("R4 wb count", 512'(wb_count), 512'(1));
    chk("R12 wb line address", 512'(last_wb_addr), 512'(1));
    chk("R4 wb data", 512'(last_wb_data[63:0]), 512'(64'hDEADBEEF0A090807));

    // R8 disarmed line evicts as zeros
    run_req(2'd2, 16'h0280, 2'd0, 512'h0, d, v);
    chk("R6 arm line 10", 512'(v), 512'(0));
    chk("R8 wb addr", 512'(last_wb_addr), 512'(2));
    chk("R8 wb zeros", last_wb_data, 512'(0));

    // R5 armed line evicts as the token
    run_req(2'd0, 16'h0080, 2'd3, 512'h0, d, v);
    chk("R5 wb count", 512'(wb_count), 512'(3));
    chk("R5 wb addr", 512'(last_wb_addr), 512'(10));
    chk("R5 wb token", last_wb_data, TOKEN);
    chk("R8 reload zeros", 512'(d), 512'(0));

    // R9 misaligned disarm: violation, no memory traffic
    f0 = fill_count; w0 = wb_count;
    run_req(2'd3, 16'h0284, 2'd0, 512'h0, d, v);
    chk("R9 viol", 512'(v), 512'(1));
    chk("R9 no fill", 512'(fill_count), 512'(f0));
    chk("R9 no wb", 512'(wb_count), 512'(w0));

    // R13 mid-run reset invalidates all lines
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 viol low", 512'(rsp_viol), 512'(0));
    rst = 1'b0;
    f0 = fill_count; w0 = wb_count;
    run_req(2'd0, 16'h0044, 2'd2, 512'h0, d, v);
    chk("R13 refill", 512'(fill_count), 512'(f0 + 1));
    chk("R13 no wb", 512'(wb_count), 512'(w0));
    chk("R13 data", 512'(d), 512'(64'hDEADBEEF));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule